// File: doc/BRIEF.md
# Rotating-Priority Interrupt Request Resolver

This block is the decision core of an eight-input interrupt controller. It captures eight request lines into a request register. A trigger-select register chooses, for each line, whether the line is captured on a rising change or follows its level. An in-service register records which interrupts the processor has taken and not yet finished. On every clock a rotating priority search finds two things: the best pending request that is not masked, and the best level currently in service. The block raises its pending flag only when the request beats the in-service level strictly. Alongside the flag it reports the number of the winning line.

The priority order can be rotated by a base offset, so any line can be made the most urgent. Two options change how the in-service level is computed. Special-mask operation drops masked in-service levels from it. Cascade-nesting operation, on a master controller, drops the cascade input from it. Software-facing programming, cascading between controllers and vector formation are handled outside. This block only receives the decoded mask, the base, the mode bits, an acknowledge strobe and an end-of-interrupt command. Request lines are assumed to be synchronous to `clk`.

Top module: `irq_rotprio_core`

## Requirements
- R1: For a line whose trigger-select bit is 0 (edge), a low-to-high change of the line, judged against the line level stored on the previous clock, sets its request bit. A line held high sets it only once. A low level never clears the request bit.
- R2: For a line whose trigger-select bit is 1 (level), the request bit follows the line on every clock, set while high and clear while low.
- R3: Priority rank p (0 most urgent) belongs to line (p + `prio_base`) mod 8, and `int_line` reports that line number.
- R4: A request whose `irq_mask` bit is 1 never wins and never causes `int_pend`.
- R5: `int_pend` is raised only when the best unmasked request has a strictly more urgent rank than the best in-service line. An equal or less urgent request stays pending silently.
- R6: With `spec_mask_en` = 1, in-service lines whose mask bit is 1 are left out of the in-service comparison.
- R7: With `nest_casc_en` = 1 and `is_master` = 1, in-service line 2 (the cascade input) is left out of the in-service comparison. Either bit at 0 keeps it in.
- R8: An `ack` while `int_pend` = 1 sets the in-service bit of `int_line`. It clears that line's request bit only if the line is edge triggered. A level-triggered request stays set.
- R9: `eoi_en` = 1 clears the in-service bit selected by `eoi_line`.
- R10: `init_clr` clears the request, stored-level and in-service registers and the outputs, but keeps the trigger-select register. Only `rst_n` clears the trigger-select register, to all-edge.
- R11: The outputs are registered. They reflect request-register changes two clocks after a line change, and mask, base or mode changes one clock after. `int_pend` falls on the first clock with no qualifying request.
- R12: While `rst_n` is low, `int_pend` and `int_line` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low hardware reset, released synchronously inside |
| init_clr | input | 1 | Synchronous controller initialisation clear |
| irq_lines | input | 8 | Interrupt request lines |
| irq_mask | input | 8 | Mask, 1 blocks a line |
| trig_we | input | 1 | Load enable for the trigger-select register |
| trig_din | input | 8 | Trigger-select value, 1 = level, 0 = edge |
| prio_base | input | 3 | Line that holds priority rank 0 |
| spec_mask_en | input | 1 | Special-mask operation enable |
| nest_casc_en | input | 1 | Cascade-nesting operation enable |
| is_master | input | 1 | Controller is the master of a cascade |
| ack | input | 1 | Interrupt acknowledge strobe |
| eoi_en | input | 1 | End-of-interrupt strobe |
| eoi_line | input | 3 | Line whose in-service bit is cleared |
| int_pend | output | 1 | Interrupt request to the processor |
| int_line | output | 3 | Winning line number, 0 when idle |

## Verification
Three timing classes matter here. A change on `irq_lines`, an `ack` or an `eoi_en` first lands in the request or in-service register and reaches `int_pend`/`int_line` on the second rising edge. A change on the mask, base or mode inputs reaches them on the first edge. `rst_n` clears the outputs at once. The bench drives every input on a falling edge. After each stimulus it waits two rising edges before sampling on the following falling edge, which covers both latencies. The one exception is the reset check, which samples a moment after `rst_n` falls.

// File: rtl/irq_rotprio_pkg.sv
package irq_rotprio_pkg;
  // default controller geometry
  localparam int unsigned DEF_LINES   = 8;
  localparam int unsigned DEF_CASCADE = 2;
endpackage

// File: rtl/irq_rst_sync.sv
module irq_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sn
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sn = sync_q[1];
endmodule

// File: rtl/irq_capture.sv
module irq_capture #(
  parameter int unsigned N_LINES = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init_clr,
  input  logic [N_LINES-1:0] lines,
  input  logic [N_LINES-1:0] trig,
  input  logic [N_LINES-1:0] ack_clr,
  output logic [N_LINES-1:0] irr_q
);
  logic [N_LINES-1:0] prev_q;
  logic [N_LINES-1:0] irr_nxt;
  logic [N_LINES-1:0] prev_nxt;

  always_comb begin
    for (int i = 0; i < N_LINES; i++) begin
      if (init_clr) begin
        irr_nxt[i]  = 1'b0;
        prev_nxt[i] = 1'b0;
      end else if (trig[i]) begin
        irr_nxt[i]  = lines[i];
        prev_nxt[i] = lines[i];
      end else begin
        irr_nxt[i]  = (irr_q[i] & ~ack_clr[i]) | (lines[i] & ~prev_q[i]);
        prev_nxt[i] = lines[i];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      irr_q  <= '0;
      prev_q <= '0;
    end else begin
      irr_q  <= irr_nxt;
      prev_q <= prev_nxt;
    end
  end

  for (genvar i = 0; i < N_LINES; i++) begin : g_chk
    // R1
    edge_rise_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(irr_q[i]) && !$past(trig[i])) |-> ($past(lines[i]) && !$past(prev_q[i])));
    // R2
    level_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(trig[i]) && !$past(init_clr)) |-> (irr_q[i] == $past(lines[i])));
  end
endmodule

// File: rtl/irq_prio_find.sv
module irq_prio_find #(
  parameter  int unsigned N_LINES = 8,
  localparam int unsigned IDX_W   = $clog2(N_LINES)
) (
  input  logic [N_LINES-1:0] vec,
  input  logic [IDX_W-1:0]   base,
  output logic [IDX_W:0]     prio
);
  localparam int unsigned PRIO_W = IDX_W + 1;

  logic [N_LINES-1:0] rot;

  // rank p looks at line (p + base) mod N_LINES
  for (genvar p = 0; p < N_LINES; p++) begin : g_rot
    assign rot[p] = vec[IDX_W'(p) + base];
  end

  always_comb begin
    prio = PRIO_W'(N_LINES);
    for (int p = N_LINES - 1; p >= 0; p--) begin
      if (rot[p]) prio = PRIO_W'(p);
    end
  end
endmodule

// File: rtl/irq_rotprio_core.sv
module irq_rotprio_core
  import irq_rotprio_pkg::*;
#(
  parameter  int unsigned N_LINES   = DEF_LINES,
  parameter  int unsigned CASC_LINE = DEF_CASCADE,
  localparam int unsigned IDX_W     = $clog2(N_LINES)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               init_clr,
  input  logic [N_LINES-1:0] irq_lines,
  input  logic [N_LINES-1:0] irq_mask,
  input  logic               trig_we,
  input  logic [N_LINES-1:0] trig_din,
  input  logic [IDX_W-1:0]   prio_base,
  input  logic               spec_mask_en,
  input  logic               nest_casc_en,
  input  logic               is_master,
  input  logic               ack,
  input  logic               eoi_en,
  input  logic [IDX_W-1:0]   eoi_line,
  output logic               int_pend,
  output logic [IDX_W-1:0]   int_line
);
  localparam logic [N_LINES-1:0] CASC_OH = N_LINES'(1) << CASC_LINE;

  logic               rst_sn;
  logic [N_LINES-1:0] trig_q;
  logic [N_LINES-1:0] irr_q;
  logic [N_LINES-1:0] isr_q, isr_nxt;
  logic [N_LINES-1:0] win_oh, eoi_oh, ack_clr, casc_ex;
  logic [N_LINES-1:0] req_vec, cur_vec;
  logic [IDX_W:0]     req_prio, cur_prio;
  logic               ack_take;
  logic               pend_q, pend_nxt;
  logic [IDX_W-1:0]   line_q, line_nxt;

  irq_rst_sync u_rst (
    .clk    (clk),
    .rst_n  (rst_n),
    .rst_sn (rst_sn)
  );

  // trigger select: hardware reset only, untouched by init_clr
  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn)      trig_q <= '0;
    else if (trig_we) trig_q <= trig_din;
  end

  assign ack_take = ack & pend_q;
  assign win_oh   = N_LINES'(1) << line_q;
  assign eoi_oh   = N_LINES'(1) << eoi_line;
  assign ack_clr  = ack_take ? win_oh : '0;

  irq_capture #(.N_LINES(N_LINES)) u_cap (
    .clk      (clk),
    .rst_n    (rst_sn),
    .init_clr (init_clr),
    .lines    (irq_lines),
    .trig     (trig_q),
    .ack_clr  (ack_clr),
    .irr_q    (irr_q)
  );

  // resolver inputs
  assign casc_ex = (nest_casc_en && is_master) ? CASC_OH : '0;
  assign req_vec = irr_q & ~irq_mask;
  assign cur_vec = isr_q & (spec_mask_en ? ~irq_mask : '1) & ~casc_ex;

  irq_prio_find #(.N_LINES(N_LINES)) u_req_find (
    .vec  (req_vec),
    .base (prio_base),
    .prio (req_prio)
  );

  irq_prio_find #(.N_LINES(N_LINES)) u_cur_find (
    .vec  (cur_vec),
    .base (prio_base),
    .prio (cur_prio)
  );

  // next state
  always_comb begin
    isr_nxt = isr_q;
    if (ack_take) isr_nxt = isr_nxt | win_oh;
    if (eoi_en)   isr_nxt = isr_nxt & ~eoi_oh;
    if (init_clr) isr_nxt = '0;

    pend_nxt = (req_prio < cur_prio) && !init_clr;
    line_nxt = pend_nxt ? IDX_W'(req_prio[IDX_W-1:0] + prio_base) : '0;
  end

  always_ff @(posedge clk or negedge rst_sn) begin
    if (!rst_sn) begin
      isr_q  <= '0;
      pend_q <= 1'b0;
      line_q <= '0;
    end else begin
      isr_q  <= isr_nxt;
      pend_q <= pend_nxt;
      line_q <= line_nxt;
    end
  end

  assign int_pend = pend_q;
  assign int_line = line_q;

  for (genvar i = 0; i < N_LINES; i++) begin : g_isr_chk
    // R8
    isr_from_ack_chk: assert property (@(posedge clk) disable iff (!rst_sn)
      $rose(isr_q[i]) |-> ($past(ack) && $past(pend_q) && ($past(line_q) == IDX_W'(i))));
  end

  // R11
  idle_drop_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (req_vec == '0) |=> !pend_q);

  // R10
  trig_hold_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    !trig_we |=> $stable(trig_q));

  // R4
  masked_winner_chk: assert property (@(posedge clk) disable iff (!rst_sn)
    (irq_mask == '1) |=> !pend_q);
endmodule

// File: tb/irq_rotprio_core_tb.sv
module irq_rotprio_core_tb;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       init_clr;
  logic [7:0] irq_lines, irq_mask, trig_din;
  logic       trig_we;
  logic [2:0] prio_base, eoi_line;
  logic       spec_mask_en, nest_casc_en, is_master, ack, eoi_en;
  logic       int_pend;
  logic [2:0] int_line;

  int checks   = 0;
  int failures = 0;
  bit done     = 0;

  always #10 clk = ~clk;

  irq_rotprio_core u_dut (
    .clk(clk), .rst_n(rst_n), .init_clr(init_clr), .irq_lines(irq_lines),
    .irq_mask(irq_mask), .trig_we(trig_we), .trig_din(trig_din),
    .prio_base(prio_base), .spec_mask_en(spec_mask_en),
    .nest_casc_en(nest_casc_en), .is_master(is_master), .ack(ack),
    .eoi_en(eoi_en), .eoi_line(eoi_line), .int_pend(int_pend),
    .int_line(int_line)
  );

  typedef struct packed {
    logic [7:0] lines;
    logic [7:0] mask;
    logic [2:0] base;
    logic       pend;
    logic [2:0] line;
  } vec_t;

  // level-triggered lines, nothing in service
  localparam vec_t VECS [10] = '{
    '{8'h00, 8'h00, 3'd0, 1'b0, 3'd0},
    '{8'h01, 8'h00, 3'd0, 1'b1, 3'd0},
    '{8'h88, 8'h00, 3'd0, 1'b1, 3'd3},
    '{8'h88, 8'h00, 3'd4, 1'b1, 3'd7},
    '{8'h88, 8'h80, 3'd4, 1'b1, 3'd3},
    '{8'hFF, 8'hFF, 3'd0, 1'b0, 3'd0},
    '{8'h24, 8'h00, 3'd3, 1'b1, 3'd5},
    '{8'h24, 8'h00, 3'd6, 1'b1, 3'd2},
    '{8'h01, 8'h00, 3'd1, 1'b1, 3'd0},
    '{8'h40, 8'h3F, 3'd7, 1'b1, 3'd6}
  };

  task automatic settle(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic check(input string req, input logic p, input logic [2:0] l,
                       input logic ep, input logic [2:0] el);
    checks++;
    if (p !== ep || (ep && l !== el)) begin
      failures++;
      $display("FAIL %s: pend=%0b line=%0d expected pend=%0b line=%0d", req, p, l, ep, el);
    end
  endtask

  task automatic pulse_ack;
    ack = 1'b1; @(negedge clk); ack = 1'b0;
    settle(2);
  endtask

  task automatic do_eoi(input logic [2:0] ln);
    eoi_line = ln; eoi_en = 1'b1; @(negedge clk); eoi_en = 1'b0;
    settle(2);
  endtask

  task automatic do_init;
    init_clr = 1'b1; @(negedge clk); init_clr = 1'b0;
  endtask

  task automatic load_trig(input logic [7:0] t);
    trig_din = t; trig_we = 1'b1; @(negedge clk); trig_we = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog: expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; init_clr = 0; irq_lines = 0; irq_mask = 0; trig_din = 0;
    trig_we = 0; prio_base = 0; eoi_line = 0; spec_mask_en = 0;
    nest_casc_en = 0; is_master = 0; ack = 0; eoi_en = 0;
    settle(3);
    check("R12 reset", int_pend, int_line, 1'b0, 3'd0);
    rst_n = 1'b1;
    settle(4);
    check("R12 after release", int_pend, int_line, 1'b0, 3'd0);

    // R3 R4 table walk
    load_trig(8'hFF);
    for (int k = 0; k < 10; k++) begin
      irq_lines = VECS[k].lines; irq_mask = VECS[k].mask; prio_base = VECS[k].base;
      settle(2);
      check($sformatf("R3 R4 vec%0d", k), int_pend, int_line, VECS[k].pend, VECS[k].line);
    end
    irq_lines = 0; irq_mask = 0; prio_base = 0;
    settle(2);
    check("R2 R11 level drop", int_pend, int_line, 1'b0, 3'd0);

    // R1 edge capture
    load_trig(8'h00); do_init;
    irq_lines = 8'h20; settle(2);
    check("R1 rising sets", int_pend, int_line, 1'b1, 3'd5);
    pulse_ack;
    check("R8 edge cleared held high", int_pend, int_line, 1'b0, 3'd0);
    do_eoi(3'd5);
    check("R1 no retrigger held", int_pend, int_line, 1'b0, 3'd0);
    irq_lines = 8'h00; @(negedge clk); irq_lines = 8'h20; settle(2);
    check("R1 new rise", int_pend, int_line, 1'b1, 3'd5);
    do_init; irq_lines = 8'h00; settle(2);
    irq_lines = 8'h02; @(negedge clk); irq_lines = 8'h00; settle(3);
    check("R1 low keeps request", int_pend, int_line, 1'b1, 3'd1);

    // R5 R8 R9 nesting with level lines
    load_trig(8'hFF); do_init;
    irq_lines = 8'h08; settle(2);
    check("R2 level sets", int_pend, int_line, 1'b1, 3'd3);
    pulse_ack;
    check("R5 equal rank silent", int_pend, int_line, 1'b0, 3'd0);
    irq_lines = 8'h0A; settle(2);
    check("R5 higher nests", int_pend, int_line, 1'b1, 3'd1);
    irq_lines = 8'h28; settle(2);
    check("R5 lower blocked", int_pend, int_line, 1'b0, 3'd0);
    do_eoi(3'd3);
    check("R9 R8 level kept", int_pend, int_line, 1'b1, 3'd3);

    // R6 special mask
    do_init; irq_lines = 8'h08; settle(2); pulse_ack;
    irq_lines = 8'h20; irq_mask = 8'h08; spec_mask_en = 1; settle(2);
    check("R6 special mask on", int_pend, int_line, 1'b1, 3'd5);
    spec_mask_en = 0; settle(2);
    check("R6 special mask off", int_pend, int_line, 1'b0, 3'd0);
    irq_mask = 0;

    // R7 cascade nesting
    do_init; irq_lines = 8'h04; settle(2); pulse_ack;
    check("R7 base blocked", int_pend, int_line, 1'b0, 3'd0);
    nest_casc_en = 1; is_master = 1; settle(2);
    check("R7 master nest", int_pend, int_line, 1'b1, 3'd2);
    is_master = 0; settle(2);
    check("R7 not master", int_pend, int_line, 1'b0, 3'd0);
    nest_casc_en = 0; is_master = 1; settle(2);
    check("R7 nest off", int_pend, int_line, 1'b0, 3'd0);
    is_master = 0;

    // R10 init keeps trigger select
    irq_lines = 8'h08; settle(2);
    load_trig(8'h08); irq_lines = 8'h00; do_init; settle(2);
    check("R10 init clears", int_pend, int_line, 1'b0, 3'd0);
    irq_lines = 8'h08; @(negedge clk); irq_lines = 8'h00; settle(3);
    check("R10 level retained", int_pend, int_line, 1'b0, 3'd0);
    irq_lines = 8'h10; settle(2);
    check("R1 edge line after init", int_pend, int_line, 1'b1, 3'd4);
    rst_n = 1'b0; #1;
    check("R12 async clear", int_pend, int_line, 1'b0, 3'd0);
    irq_lines = 8'h00; settle(1); rst_n = 1'b1; settle(4);
    irq_lines = 8'h08; @(negedge clk); irq_lines = 8'h00; settle(3);
    check("R10 reset restores edge", int_pend, int_line, 1'b1, 3'd3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule